// File: doc/BRIEF.md
# Signed Integer Encoding Converter

This unit converts signed integers between three encodings: sign-magnitude, one's complement and two's complement. The target width is 8 or 16 bits. In the encode direction it takes a 32-bit two's complement value and writes out its pattern in the chosen format. It raises an overflow flag when that format and width cannot represent the value. The three formats cover different ranges. Sign-magnitude and one's complement stop at ±(2^(W-1)-1) and have two zeros. Two's complement reaches down to -2^(W-1) and has one zero.

In the decode direction the unit reads a pattern in any of the three formats and returns the value as a sign-extended 32-bit two's complement number. It flags the negative-zero patterns of the two dual-zero formats and returns 0 for them.

Transfers use a valid/ready handshake at both the input and the output. A two-state controller owns the single result register, so a result appears one cycle after its request is accepted. The controller states are:
- `ST_EMPTY`: no result is held.
- `ST_FULL`: a result is held.

The transitions are:
- `ACCEPT`: `ST_EMPTY` to `ST_FULL`.
- `DRAIN`: `ST_FULL` to `ST_EMPTY`, when the result leaves and no new request arrives.
- `REFILL`: `ST_FULL` to `ST_FULL`, when the result leaves and a new request is taken in the same cycle.
- `STALL`: `ST_FULL` to `ST_FULL`, when the output is not ready.

Top module: `sint_recode`

## Requirements
- R1: A request is accepted on a clock edge where `in_valid` and `in_ready` are both 1, and its result is on the outputs with `out_valid`=1 after that edge. `in_ready` is 1 whenever no result is held or `out_ready` is 1. A held result, with its flags, stays unchanged while `out_ready` is 0. After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Encode to sign-magnitude (`in_fmt`=0) puts the sign in bit W-1 and the magnitude in bits W-2..0. The representable range is -(2^(W-1)-1)..+(2^(W-1)-1). A value of 0 encodes as all zeros.
- R3: Encode to one's complement (`in_fmt`=1) writes non-negative values unchanged. A negative value becomes the bitwise inversion, within W bits, of its magnitude. The range is the same as in R2.
- R4: Encode to two's complement (`in_fmt`=2, and also `in_fmt`=3) writes the low W bits of the value. The range is -2^(W-1)..+2^(W-1)-1.
- R5: An encode request whose value lies outside the target range sets `out_ovf`=1 and forces `out_data` to 0. Examples are +258 and -24760 at 8 bits.
- R6: `in_wide`=0 selects W=8 and `in_wide`=1 selects W=16. Encode results have zeros in every `out_data` bit at or above W.
- R7: Decode (`in_dir`=1) of a sign-magnitude pattern returns the sign-extended 32-bit value. For example, 8'hBB gives -59.
- R8: Decode of a one's complement pattern inverts a negative pattern to obtain its magnitude. Decode of a two's complement pattern sign-extends from bit W-1. Decoding an encoded value returns the original value. Decode never sets `out_ovf`.
- R9: The decode patterns sign bit alone (sign-magnitude) and all ones (one's complement) set `out_negz`=1 and return 0, at either width. Two's complement never sets `out_negz`.
- R10: In decode, the `in_data` bits at or above W have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_dir | input | 1 | 0 = encode, 1 = decode |
| in_fmt | input | 2 | 0 sign-magnitude, 1 one's complement, 2 or 3 two's complement |
| in_wide | input | 1 | 0 = 8-bit, 1 = 16-bit target |
| in_data | input | 32 | Encode: two's complement value; decode: pattern in low W bits |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 32 | Encode: zero-extended pattern; decode: sign-extended value |
| out_ovf | output | 1 | Value not representable (encode only) |
| out_negz | output | 1 | Negative-zero pattern decoded |

## Verification
The assertions take the handshake on trust. They assume that `in_valid`, the request fields and `out_ready` are settled before each rising edge, and that the consumer obeys `out_ready` alone. The flag checks also assume that overflow and negative zero can only come from the encode and decode paths respectively. The bench drives every input on the falling edge and keeps request fields constant while `in_valid` is high and not yet accepted. It uses only defined values on all inputs, so each edge sees one stable request.

// File: rtl/sint_pkg.sv
package sint_pkg;
    localparam int DATA_W = 32;

    typedef enum logic [1:0] {
        FMT_SMAG  = 2'd0,
        FMT_ONES  = 2'd1,
        FMT_TWOS  = 2'd2,
        FMT_TWOS3 = 2'd3
    } fmt_e;

    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } st_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              ovf;
        logic              negz;
    } res_t;
endpackage

// File: rtl/sint_enc.sv
module sint_enc
    import sint_pkg::*;
#(
    parameter int NW = 8,
    parameter int WW = 16
) (
    input  logic [1:0]        fmt,
    input  logic              wide,
    input  logic [DATA_W-1:0] value,
    output res_t              res
);
    localparam logic [DATA_W-1:0] LIM_N  = DATA_W'((64'd1 << (NW-1)) - 64'd1);
    localparam logic [DATA_W-1:0] LIM_W  = DATA_W'((64'd1 << (WW-1)) - 64'd1);
    localparam logic [DATA_W-1:0] MASK_N = DATA_W'((64'd1 << NW) - 64'd1);
    localparam logic [DATA_W-1:0] MASK_W = DATA_W'((64'd1 << WW) - 64'd1);
    localparam logic [DATA_W-1:0] SB_N   = DATA_W'(64'd1 << (NW-1));
    localparam logic [DATA_W-1:0] SB_W   = DATA_W'(64'd1 << (WW-1));

    logic              neg;
    logic [DATA_W-1:0] mag, lim, mask, sbit, pat;
    logic              ovf;

    always_comb begin
        neg  = value[DATA_W-1];
        mag  = neg ? (~value + DATA_W'(1)) : value;
        lim  = wide ? LIM_W  : LIM_N;
        mask = wide ? MASK_W : MASK_N;
        sbit = wide ? SB_W   : SB_N;
        unique case (fmt_e'(fmt))
            FMT_SMAG: begin
                ovf = (mag > lim);
                pat = neg ? (sbit | mag) : mag;
            end
            FMT_ONES: begin
                ovf = (mag > lim);
                pat = neg ? ~mag : mag;
            end
            FMT_TWOS, FMT_TWOS3: begin
                ovf = neg ? (mag > lim + DATA_W'(1)) : (mag > lim);
                pat = value;
            end
        endcase
        res.ovf  = ovf;
        res.negz = 1'b0;
        res.data = ovf ? '0 : (pat & mask);
    end
endmodule

// File: rtl/sint_dec.sv
module sint_dec
    import sint_pkg::*;
#(
    parameter int NW = 8,
    parameter int WW = 16
) (
    input  logic [1:0]        fmt,
    input  logic              wide,
    input  logic [DATA_W-1:0] pattern,
    output res_t              res
);
    localparam logic [DATA_W-1:0] MASK_N = DATA_W'((64'd1 << NW) - 64'd1);
    localparam logic [DATA_W-1:0] MASK_W = DATA_W'((64'd1 << WW) - 64'd1);
    localparam logic [DATA_W-1:0] SB_N   = DATA_W'(64'd1 << (NW-1));
    localparam logic [DATA_W-1:0] SB_W   = DATA_W'(64'd1 << (WW-1));

    logic [DATA_W-1:0] mask, sbit, p, m;
    logic              sgn;

    always_comb begin
        mask = wide ? MASK_W : MASK_N;
        sbit = wide ? SB_W   : SB_N;
        p    = pattern & mask;
        sgn  = |(p & sbit);
        res.ovf = 1'b0;
        unique case (fmt_e'(fmt))
            FMT_SMAG: begin
                m        = p & ~sbit;
                res.data = sgn ? (~m + DATA_W'(1)) : m;
                res.negz = sgn && (m == '0);
            end
            FMT_ONES: begin
                m        = sgn ? (~p & mask) : p;
                res.data = sgn ? (~m + DATA_W'(1)) : m;
                res.negz = sgn && (m == '0);
            end
            FMT_TWOS, FMT_TWOS3: begin
                m        = p;
                res.data = sgn ? (p | ~mask) : p;
                res.negz = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/sint_ctrl.sv
module sint_ctrl
    import sint_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic in_valid,
    input  logic out_ready,
    output logic in_ready,
    output logic out_valid,
    output logic load
);
    st_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_EMPTY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_EMPTY: if (in_valid) state_nx = ST_FULL;               // ACCEPT
            ST_FULL:  if (out_ready && !in_valid) state_nx = ST_EMPTY; // DRAIN
                      // REFILL and STALL keep ST_FULL
        endcase
    end

    always_comb begin
        out_valid = (state == ST_FULL);
        in_ready  = (state == ST_EMPTY) || out_ready;
        load      = in_valid && in_ready;
    end
endmodule

// File: rtl/sint_recode.sv
module sint_recode
    import sint_pkg::*;
#(
    parameter int NW = 8,
    parameter int WW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic              in_dir,
    input  logic [1:0]        in_fmt,
    input  logic              in_wide,
    input  logic [DATA_W-1:0] in_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_ovf,
    output logic              out_negz
);
    res_t enc_res, dec_res, sel_res, held;
    logic load;

    sint_enc #(.NW(NW), .WW(WW)) u_enc (
        .fmt(in_fmt), .wide(in_wide), .value(in_data), .res(enc_res)
    );

    sint_dec #(.NW(NW), .WW(WW)) u_dec (
        .fmt(in_fmt), .wide(in_wide), .pattern(in_data), .res(dec_res)
    );

    sint_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .out_ready(out_ready),
        .in_ready(in_ready), .out_valid(out_valid), .load(load)
    );

    assign sel_res = in_dir ? dec_res : enc_res;

    always_ff @(posedge clk) begin
        if (!rst_n)    held <= '0;
        else if (load) held <= sel_res;
    end

    assign out_data = held.data;
    assign out_ovf  = held.ovf;
    assign out_negz = held.negz;
endmodule

// File: rtl/sint_recode_chk.sv
module sint_recode_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        in_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        out_ovf,
    input logic        out_negz
);
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid); // R1
    AST_READY_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> in_ready); // R1
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_ovf) && $stable(out_negz)); // R1
    AST_OVF_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ovf |-> out_data == 32'd0); // R5
    AST_NEGZ_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_negz |-> out_data == 32'd0 && !out_ovf); // R9
endmodule

bind sint_recode sint_recode_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_ovf(out_ovf), .out_negz(out_negz)
);

// File: tb/sim_sint_recode.sv
module sim_sint_recode;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid, in_ready, in_dir, in_wide;
    logic [1:0]  in_fmt;
    logic [31:0] in_data;
    logic        out_valid, out_ready, out_ovf, out_negz;
    logic [31:0] out_data;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    sint_recode u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .in_dir(in_dir), .in_fmt(in_fmt), .in_wide(in_wide), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_ovf(out_ovf), .out_negz(out_negz)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One request with the output always ready; sample after the accepting edge.
    task automatic xfer(input string req, input bit dir, input logic [1:0] fmt, input bit wide,
                        input logic [31:0] din, input logic [31:0] exp_d,
                        input bit exp_ovf, input bit exp_nz);
        @(negedge clk);
        out_ready = 1'b1;
        in_valid = 1'b1; in_dir = dir; in_fmt = fmt; in_wide = wide; in_data = din;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && out_data === exp_d && out_ovf === exp_ovf && out_negz === exp_nz,
            req, out_data, exp_d);
    endtask

    task automatic t_reset;
        chk(out_valid === 1'b0, "R1 reset out_valid", {31'd0, out_valid}, 32'd0);
        chk(in_ready === 1'b1, "R1 reset in_ready", {31'd0, in_ready}, 32'd1);
    endtask

    task automatic t_smag_encode;
        xfer("R2 smag +7",    0, 2'd0, 0, 32'd7,          32'h07, 0, 0);
        xfer("R2 smag -7",    0, 2'd0, 0, -32'sd7,        32'h87, 0, 0);
        xfer("R2 smag -124",  0, 2'd0, 0, -32'sd124,      32'hFC, 0, 0);
        xfer("R2 smag -127",  0, 2'd0, 0, -32'sd127,      32'hFF, 0, 0);
        xfer("R2 smag zero",  0, 2'd0, 0, 32'd0,          32'h00, 0, 0);
        xfer("R6 smag16 -24760", 0, 2'd0, 1, -32'sd24760, 32'hE0B8, 0, 0);
    endtask

    task automatic t_ones_encode;
        xfer("R3 ones -7",    0, 2'd1, 0, -32'sd7,        32'hF8, 0, 0);
        xfer("R3 ones +124",  0, 2'd1, 0, 32'd124,        32'h7C, 0, 0);
        xfer("R3 ones -127",  0, 2'd1, 0, -32'sd127,      32'h80, 0, 0);
        xfer("R6 ones16 -24760", 0, 2'd1, 1, -32'sd24760, 32'h9F47, 0, 0);
        xfer("R6 ones16 +32767", 0, 2'd1, 1, 32'd32767,   32'h7FFF, 0, 0);
    endtask

    task automatic t_twos_encode;
        xfer("R4 twos -7",    0, 2'd2, 0, -32'sd7,        32'hF9, 0, 0);
        xfer("R4 twos -128",  0, 2'd2, 0, -32'sd128,      32'h80, 0, 0);
        xfer("R4 fmt3 -7",    0, 2'd3, 0, -32'sd7,        32'hF9, 0, 0);
        xfer("R6 twos16 -24760", 0, 2'd2, 1, -32'sd24760, 32'h9F48, 0, 0);
        xfer("R6 twos16 -32768", 0, 2'd2, 1, -32'sd32768, 32'h8000, 0, 0);
    endtask

    task automatic t_overflow;
        xfer("R5 smag -128",  0, 2'd0, 0, -32'sd128,      32'h0, 1, 0);
        xfer("R5 ones -128",  0, 2'd1, 0, -32'sd128,      32'h0, 1, 0);
        xfer("R5 smag +258",  0, 2'd0, 0, 32'd258,        32'h0, 1, 0);
        xfer("R5 twos +128",  0, 2'd2, 0, 32'd128,        32'h0, 1, 0);
        xfer("R5 twos -129",  0, 2'd2, 0, -32'sd129,      32'h0, 1, 0);
        xfer("R5 twos -24760 at 8", 0, 2'd2, 0, -32'sd24760, 32'h0, 1, 0);
        xfer("R5 smag16 -32768", 0, 2'd0, 1, -32'sd32768, 32'h0, 1, 0);
        xfer("R5 twos16 +32768", 0, 2'd2, 1, 32'd32768,   32'h0, 1, 0);
    endtask

    task automatic t_decode;
        xfer("R7 smag 0xBB",  1, 2'd0, 0, 32'hBB,         32'hFFFFFFC5, 0, 0);
        xfer("R7 smag 0x3B",  1, 2'd0, 0, 32'h3B,         32'd59, 0, 0);
        xfer("R8 ones 0xF8",  1, 2'd1, 0, 32'hF8,         32'hFFFFFFF9, 0, 0);
        xfer("R8 ones16 0x9F47", 1, 2'd1, 1, 32'h9F47,    32'hFFFF9F48, 0, 0);
        xfer("R8 twos 0x80",  1, 2'd2, 0, 32'h80,         32'hFFFFFF80, 0, 0);
        xfer("R8 twos16 0x7FFF", 1, 2'd2, 1, 32'h7FFF,    32'd32767, 0, 0);
        xfer("R10 smag upper bits", 1, 2'd0, 0, 32'hABCD12BB, 32'hFFFFFFC5, 0, 0);
        xfer("R10 twos upper bits", 1, 2'd2, 1, 32'hFFFF0005, 32'd5, 0, 0);
    endtask

    task automatic t_negzero;
        xfer("R9 smag 0x80",    1, 2'd0, 0, 32'h80,    32'h0, 0, 1);
        xfer("R9 ones 0xFF",    1, 2'd1, 0, 32'hFF,    32'h0, 0, 1);
        xfer("R9 smag16 0x8000", 1, 2'd0, 1, 32'h8000, 32'h0, 0, 1);
        xfer("R9 ones16 0xFFFF", 1, 2'd1, 1, 32'hFFFF, 32'h0, 0, 1);
        xfer("R9 ones 0x00",    1, 2'd1, 0, 32'h00,    32'h0, 0, 0);
    endtask

    task automatic t_roundtrip;
        logic [31:0] pat;
        xfer("R8 enc ones -100", 0, 2'd1, 0, -32'sd100, 32'h9B, 0, 0);
        pat = out_data;
        xfer("R8 dec ones back", 1, 2'd1, 0, pat, -32'sd100, 0, 0);
    endtask

    task automatic t_stall;
        @(negedge clk);
        out_ready = 1'b0;
        in_valid = 1'b1; in_dir = 1'b0; in_fmt = 2'd2; in_wide = 1'b0; in_data = -32'sd7;
        @(negedge clk);
        chk(out_valid === 1'b1 && out_data === 32'hF9, "R1 stall first", out_data, 32'hF9);
        chk(in_ready === 1'b0, "R1 stall in_ready low", {31'd0, in_ready}, 32'd0);
        in_data = 32'd5;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b1 && out_data === 32'hF9, "R1 stall hold", out_data, 32'hF9);
        end
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid === 1'b1 && out_data === 32'h05, "R1 refill", out_data, 32'h05);
        @(negedge clk);
        chk(out_valid === 1'b0, "R1 drain", {31'd0, out_valid}, 32'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_dir = 1'b0; in_fmt = 2'd0;
        in_wide = 1'b0; in_data = '0; out_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_smag_encode();
        t_ones_encode();
        t_twos_encode();
        t_overflow();
        t_decode();
        t_negzero();
        t_roundtrip();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R1 watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end
endmodule